// File: doc/BRIEF.md
# NAND Flash Command Front End

This block sits on the device side of a byte-wide NAND flash bus. Every byte written on the shared 8-bit I/O bus is sorted by the two latch-enable inputs: with the command-latch enable high it is a command, with the address-latch enable high it is an address, and with both low it is program data. The block decodes the command set and counts address cycles. It builds row and column addresses and hands finished operations (page read, page program, block erase, copy-back) to an array controller stub. That stub answers with a done pulse and a pass/fail flag.

The two high column bits do not arrive in an address byte. They come from a sticky pointer region chosen by one of three read commands: the first half of the page, the second half, or the 16-byte spare area. On the read side, each falling read-strobe edge places one byte on `io_out`. That byte is the status register, an identification byte or array data, depending on the last output-selecting command. The read strobe also acts as the pop of a one-byte output stream, with `io_oe` as its valid. The write strobe and the program-data stream (`dat_valid`) carry no ready. The bus host cannot be stalled, so the array stub must take every data byte in the cycle it is offered.

Both strobes and the latch enables are sampled on `clk` and are assumed synchronous to it. The strobes idle high.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus byte is taken only in the cycle after `we_n` is sampled going from low to high. With `cle` high it is a command, with `ale` high (and `cle` low) an address, with both low it is data. A data byte outside the program data phase affects nothing.
- R2: Command 00h selects column region 0-255, 01h selects region 256-511, and 50h selects the spare area. The first address byte `b` then gives column `b`, `256+b` or `512+b[3:0]` respectively. The region persists until another of these commands and is 00h after reset.
- R3: After a read command, four address bytes are taken. Byte 0 is the column and bytes 1-3 are the row, least significant first. The fourth byte raises `op_start` for one cycle with `op_kind`=1 and raises `busy`. While idle after a read, address bytes alone start a further read in the same region.
- R4: Command 60h followed by three row bytes (least significant first) and then D0h starts an erase with `op_kind`=3 and column 0. D0h without a completed erase setup starts nothing.
- R5: Command 80h followed by four address bytes opens a data phase. Each data byte appears on `dat_byte` with `dat_valid` for one cycle, and `dat_col` counts up from the start column. Command 10h then starts a program with `op_kind`=2.
- R6: Command 8Ah is accepted only after a read has started since the last reset command. It takes four target address bytes, and 10h then starts a copy-back with `op_kind`=4. Otherwise 8Ah and the bytes after it start nothing.
- R7: After 70h, each falling read-strobe edge returns the status byte {`wp_n`, not busy, 00000, fail} on `io_out`. Fail is the `arr_fail` value captured at `arr_done` of a program, erase or copy-back. `io_oe` is high in the cycles after `re_n` is sampled low.
- R8: After 90h and one address byte, successive read strobes return ECh, 79h, A5h, C0h, and the sequence then repeats.
- R9: Command FFh clears `busy` at once, pulses `op_abort` if an operation was busy, clears fail and the pending command, and leaves status C0h with `wp_n` high or 40h with it low.
- R10: While `busy` is high, only 70h and FFh are acted on. Other commands, address bytes and data bytes are ignored, and `arr_done` clears `busy`.
- R11: An unrecognised command byte starts nothing and drops any partly entered sequence back to idle.
- R12: Address bytes beyond the count needed by the current command are ignored.
- R13: Once a read starts, the output path returns `rd_data` on each read strobe. `rd_col` starts at the read's column and advances by one per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, byte driven on its falling edge |
| wp_n | input | 1 | Write protect, low when protected |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Bus byte to the host |
| io_oe | output | 1 | Output byte valid while the read strobe is low |
| busy | output | 1 | Array operation in progress |
| op_start | output | 1 | One-cycle launch of an array operation |
| op_kind | output | 3 | 1 read, 2 program, 3 erase, 4 copy-back |
| op_row | output | 24 | Row address of the launched operation |
| op_col | output | 10 | Column of the launched operation |
| op_abort | output | 1 | One-cycle abort of a busy operation |
| arr_done | input | 1 | Array stub finished the operation |
| arr_fail | input | 1 | Array stub result, valid with arr_done |
| dat_valid | output | 1 | Program data byte valid |
| dat_byte | output | 8 | Program data byte |
| dat_col | output | 10 | Column of the program data byte |
| rd_col | output | 10 | Column the array stub must present on rd_data |
| rd_data | input | 8 | Array byte at rd_col |

## Verification
The decoder is driven with each operation's full sequence. It is also driven with sequences that are cut short, padded with surplus address bytes, interleaved with data bytes, or broken by an unknown command. Comparing the launched operations shows whether the byte classification, the address counting and the confirm commands are kept apart. The same address byte is sent under each of the three pointer regions and again without a fresh command, which separates a sticky region from one re-read on every command. Status is read idle, busy, after a failed erase and after a reset command with both write-protect levels, so each status bit is tested on its own.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam int BYTE_W = 8;
  localparam int COL_W  = 10;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_PROG  = 3'd2,
    OP_ERASE = 3'd3,
    OP_COPY  = 3'd4,
    OP_ID    = 3'd5
  } op_e;

  typedef enum logic [1:0] {PTR_LO, PTR_HI, PTR_SPARE} ptr_e;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} out_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_CONFIRM} st_e;

  localparam logic [BYTE_W-1:0] CMD_PTR_LO   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_PTR_HI   = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_PTR_SPR  = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_PROG     = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_GO       = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_COPY     = 8'h8A;
  localparam logic [BYTE_W-1:0] CMD_ERASE    = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_STATUS   = 8'h70;
  localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_RESET    = 8'hFF;

  function automatic logic [BYTE_W-1:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hEC;
      2'd1:    return 8'h79;
      2'd2:    return 8'hA5;
      default: return 8'hC0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] col_of(input ptr_e p, input logic [BYTE_W-1:0] b);
    case (p)
      PTR_LO:  return {2'b00, b};
      PTR_HI:  return {2'b01, b};
      default: return {2'b10, 4'b0000, b[3:0]};
    endcase
  endfunction

  function automatic ptr_e ptr_of(input logic [BYTE_W-1:0] code);
    if (code == CMD_PTR_HI) return PTR_HI;
    if (code == CMD_PTR_SPR) return PTR_SPARE;
    return PTR_LO;
  endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe;
  end

  generate
    if (RISE) begin : g_rise
      assign hit = strobe & ~prev_q;
    end else begin : g_fall
      assign hit = ~strobe & prev_q;
    end
  endgenerate
endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_fe_pkg::*;
#(
  parameter int ROW_CYC = 3,
  localparam int NBYTE  = ROW_CYC + 1,
  localparam int ROW_W  = BYTE_W * ROW_CYC,
  localparam int CNT_W  = $clog2(NBYTE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_edge,
  input  logic              cle,
  input  logic              ale,
  input  logic [BYTE_W-1:0] io_in,
  input  logic              arr_done,
  input  logic              arr_fail,
  output logic              busy,
  output logic              fail,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ROW_W-1:0]  op_row,
  output logic [COL_W-1:0]  op_col,
  output logic              op_abort,
  output logic              dat_valid,
  output logic [BYTE_W-1:0] dat_byte,
  output logic [COL_W-1:0]  dat_col,
  output out_e              out_sel,
  output logic              id_go,
  output logic              col_ld
);
  st_e               st_q;
  op_e               op_q, kind_q;
  ptr_e              ptr_q;
  out_e              out_q;
  logic [CNT_W-1:0]  acnt_q;
  logic [BYTE_W-1:0] abuf_q  [NBYTE];
  logic [BYTE_W-1:0] abuf_nx [NBYTE];
  logic [ROW_W-1:0]  row_nx, pend_row_q, row_q;
  logic [COL_W-1:0]  col_nx, pend_col_q, col_q, dcol_q, dat_col_q;
  logic [BYTE_W-1:0] dat_byte_q;
  logic              busy_q, fail_q, start_q, abort_q, dvld_q, id_go_q, col_ld_q;
  logic              read_arm_q, src_ok_q, last_addr;

  function automatic logic [CNT_W-1:0] need_of(input op_e op);
    case (op)
      OP_READ, OP_PROG, OP_COPY: return CNT_W'(NBYTE);
      OP_ERASE:                  return CNT_W'(ROW_CYC);
      OP_ID:                     return CNT_W'(1);
      default:                   return '0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NBYTE; i++) begin
      abuf_nx[i] = (acnt_q == CNT_W'(i)) ? io_in : abuf_q[i];
    end
  end

  always_comb begin
    for (int i = 0; i < ROW_CYC; i++) begin
      row_nx[BYTE_W*i +: BYTE_W] = (op_q == OP_ERASE) ? abuf_nx[i] : abuf_nx[i+1];
    end
    col_nx    = (op_q == OP_ERASE) ? '0 : col_of(ptr_q, abuf_nx[0]);
    last_addr = ((acnt_q + 1'b1) == need_of(op_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_NONE;
      kind_q     <= OP_NONE;
      ptr_q      <= PTR_LO;
      out_q      <= OUT_ARRAY;
      acnt_q     <= '0;
      for (int i = 0; i < NBYTE; i++) abuf_q[i] <= '0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      row_q      <= '0;
      col_q      <= '0;
      dcol_q     <= '0;
      dat_col_q  <= '0;
      dat_byte_q <= '0;
      busy_q     <= 1'b0;
      fail_q     <= 1'b0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      dvld_q     <= 1'b0;
      id_go_q    <= 1'b0;
      col_ld_q   <= 1'b0;
      read_arm_q <= 1'b0;
      src_ok_q   <= 1'b0;
    end else begin
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
      dvld_q   <= 1'b0;
      id_go_q  <= 1'b0;
      col_ld_q <= 1'b0;

      if (arr_done && busy_q) begin
        busy_q <= 1'b0;
        if (kind_q != OP_READ) fail_q <= arr_fail;
      end

      if (wr_edge) begin
        if (cle) begin
          if (io_in == CMD_RESET) begin
            busy_q     <= 1'b0;
            abort_q    <= busy_q;
            fail_q     <= 1'b0;
            st_q       <= ST_IDLE;
            acnt_q     <= '0;
            read_arm_q <= 1'b0;
            src_ok_q   <= 1'b0;
          end else if (io_in == CMD_STATUS) begin
            out_q <= OUT_STATUS;
          end else if (!busy_q) begin
            st_q   <= ST_IDLE;
            acnt_q <= '0;
            case (io_in)
              CMD_PTR_LO, CMD_PTR_HI, CMD_PTR_SPR: begin
                ptr_q      <= ptr_of(io_in);
                op_q       <= OP_READ;
                st_q       <= ST_ADDR;
                read_arm_q <= 1'b1;
              end
              CMD_PROG: begin
                op_q       <= OP_PROG;
                st_q       <= ST_ADDR;
                read_arm_q <= 1'b0;
              end
              CMD_COPY: begin
                read_arm_q <= 1'b0;
                if (src_ok_q) begin
                  op_q <= OP_COPY;
                  st_q <= ST_ADDR;
                end
              end
              CMD_ERASE: begin
                op_q       <= OP_ERASE;
                st_q       <= ST_ADDR;
                read_arm_q <= 1'b0;
              end
              CMD_IDENT: begin
                op_q       <= OP_ID;
                st_q       <= ST_ADDR;
                read_arm_q <= 1'b0;
              end
              CMD_GO: begin
                if ((st_q == ST_DATA && op_q == OP_PROG) ||
                    (st_q == ST_CONFIRM && op_q == OP_COPY)) begin
                  start_q <= 1'b1;
                  kind_q  <= op_q;
                  row_q   <= pend_row_q;
                  col_q   <= pend_col_q;
                  busy_q  <= 1'b1;
                end
              end
              CMD_ERASE_GO: begin
                if (st_q == ST_CONFIRM && op_q == OP_ERASE) begin
                  start_q <= 1'b1;
                  kind_q  <= OP_ERASE;
                  row_q   <= pend_row_q;
                  col_q   <= pend_col_q;
                  busy_q  <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (ale) begin
          if (!busy_q) begin
            if (st_q == ST_ADDR) begin
              abuf_q <= abuf_nx;
              acnt_q <= acnt_q + 1'b1;
              if (last_addr) begin
                acnt_q     <= '0;
                pend_row_q <= row_nx;
                pend_col_q <= col_nx;
                case (op_q)
                  OP_READ: begin
                    st_q     <= ST_IDLE;
                    start_q  <= 1'b1;
                    kind_q   <= OP_READ;
                    row_q    <= row_nx;
                    col_q    <= col_nx;
                    busy_q   <= 1'b1;
                    src_ok_q <= 1'b1;
                    out_q    <= OUT_ARRAY;
                    col_ld_q <= 1'b1;
                  end
                  OP_PROG: begin
                    st_q   <= ST_DATA;
                    dcol_q <= col_nx;
                  end
                  OP_COPY, OP_ERASE: st_q <= ST_CONFIRM;
                  OP_ID: begin
                    st_q    <= ST_IDLE;
                    out_q   <= OUT_ID;
                    id_go_q <= 1'b1;
                  end
                  default: st_q <= ST_IDLE;
                endcase
              end
            end else if (st_q == ST_IDLE && read_arm_q) begin
              abuf_q <= abuf_nx;
              acnt_q <= CNT_W'(1);
              op_q   <= OP_READ;
              st_q   <= ST_ADDR;
            end
          end
        end else if (!busy_q && st_q == ST_DATA) begin
          dvld_q     <= 1'b1;
          dat_byte_q <= io_in;
          dat_col_q  <= dcol_q;
          dcol_q     <= dcol_q + 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign fail      = fail_q;
  assign op_start  = start_q;
  assign op_kind   = kind_q;
  assign op_row    = row_q;
  assign op_col    = col_q;
  assign op_abort  = abort_q;
  assign dat_valid = dvld_q;
  assign dat_byte  = dat_byte_q;
  assign dat_col   = dat_col_q;
  assign out_sel   = out_q;
  assign id_go     = id_go_q;
  assign col_ld    = col_ld_q;
endmodule

// File: rtl/nand_out_path.sv
module nand_out_path
  import nand_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_edge,
  input  logic              re_n,
  input  out_e              out_sel,
  input  logic              id_go,
  input  logic              col_ld,
  input  logic [COL_W-1:0]  col_start,
  input  logic              busy,
  input  logic              fail,
  input  logic              wp_n,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe,
  output logic [COL_W-1:0]  rd_col
);
  logic [1:0]        idx_q;
  logic [COL_W-1:0]  col_q;
  logic [BYTE_W-1:0] out_q;
  logic              oe_q;
  logic [BYTE_W-1:0] status;

  assign status = {wp_n, ~busy, 5'b00000, fail};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      col_q <= '0;
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= ~re_n;
      if (id_go) idx_q <= '0;
      if (col_ld) begin
        col_q <= col_start;
      end else if (rd_edge) begin
        case (out_sel)
          OUT_STATUS: out_q <= status;
          OUT_ID: begin
            out_q <= id_byte(idx_q);
            idx_q <= idx_q + 1'b1;
          end
          default: begin
            out_q <= rd_data;
            col_q <= col_q + 1'b1;
          end
        endcase
      end
    end
  end

  assign io_out = out_q;
  assign io_oe  = oe_q;
  assign rd_col = col_q;
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int ROW_CYC = 3,
  localparam int ROW_W  = BYTE_W * ROW_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic              re_n,
  input  logic              wp_n,
  input  logic [BYTE_W-1:0] io_in,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe,
  output logic              busy,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ROW_W-1:0]  op_row,
  output logic [COL_W-1:0]  op_col,
  output logic              op_abort,
  input  logic              arr_done,
  input  logic              arr_fail,
  output logic              dat_valid,
  output logic [BYTE_W-1:0] dat_byte,
  output logic [COL_W-1:0]  dat_col,
  output logic [COL_W-1:0]  rd_col,
  input  logic [BYTE_W-1:0] rd_data
);
  logic wr_hit, rd_hit, fail_w, id_go_w, col_ld_w;
  out_e out_sel_w;

  nand_strobe_edge #(.RISE(1'b1)) i_we_edge (
    .clk(clk), .rst_n(rst_n), .strobe(we_n), .hit(wr_hit)
  );

  nand_strobe_edge #(.RISE(1'b0)) i_re_edge (
    .clk(clk), .rst_n(rst_n), .strobe(re_n), .hit(rd_hit)
  );

  nand_cmd_fsm #(.ROW_CYC(ROW_CYC)) i_fsm (
    .clk(clk), .rst_n(rst_n), .wr_edge(wr_hit), .cle(cle), .ale(ale),
    .io_in(io_in), .arr_done(arr_done), .arr_fail(arr_fail),
    .busy(busy), .fail(fail_w), .op_start(op_start), .op_kind(op_kind),
    .op_row(op_row), .op_col(op_col), .op_abort(op_abort),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_col(dat_col),
    .out_sel(out_sel_w), .id_go(id_go_w), .col_ld(col_ld_w)
  );

  nand_out_path i_out (
    .clk(clk), .rst_n(rst_n), .rd_edge(rd_hit), .re_n(re_n),
    .out_sel(out_sel_w), .id_go(id_go_w), .col_ld(col_ld_w),
    .col_start(op_col), .busy(busy), .fail(fail_w), .wp_n(wp_n),
    .rd_data(rd_data), .io_out(io_out), .io_oe(io_oe), .rd_col(rd_col)
  );
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic       cle,
  input logic [7:0] io_in,
  input logic       re_n,
  input logic       io_oe,
  input logic       busy,
  input logic       op_start,
  input logic [9:0] op_col,
  input logic       op_abort,
  input logic       dat_valid
);
  // R10: no launch while an operation is running
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(busy));

  // R3: a launch leaves the block busy
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);

  // R2: every launched column lies inside the page including spare
  p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (op_col < 10'd528));

  // R10: no program data accepted while busy
  p_no_data_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !busy);

  // R7: output valid follows a low read strobe
  p_oe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |=> io_oe);

  // R9: a reset command leaves the block idle
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cle && io_in == 8'hFF) |=> !busy);

  // R9: an abort is never reported with busy still set
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> !busy);
endmodule

bind nand_cmd_front nand_cmd_front_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .cle(cle), .io_in(io_in),
  .re_n(re_n), .io_oe(io_oe), .busy(busy), .op_start(op_start),
  .op_col(op_col), .op_abort(op_abort), .dat_valid(dat_valid)
);

// File: tb/test_nand_cmd_front.sv
module test_nand_cmd_front;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic       arr_done = 1'b0, arr_fail = 1'b0;
  logic [7:0] io_out, dat_byte, rd_data;
  logic       io_oe, busy, op_start, op_abort, dat_valid;
  logic [2:0] op_kind;
  logic [23:0] op_row;
  logic [9:0] op_col, dat_col, rd_col;

  int checks = 0, failures = 0, aborts = 0;
  bit started = 0, finished = 0, exp_busy = 0;
  int q_kind[$], q_row[$], q_col[$], q_dbyte[$], q_dcol[$];

  always #(CLK_NS/2) clk = ~clk;

  assign rd_data = rd_col[7:0] ^ 8'h5A;

  nand_cmd_front i_nand_cmd_front (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .busy(busy),
    .op_start(op_start), .op_kind(op_kind), .op_row(op_row), .op_col(op_col),
    .op_abort(op_abort), .arr_done(arr_done), .arr_fail(arr_fail),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_col(dat_col),
    .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared every clock
  always @(posedge clk) begin
    #2;
    if (started && rst_n) begin
      check(busy == exp_busy, "R10 busy flag", busy, exp_busy);
      check(io_oe == !re_n, "R7 output valid", io_oe, !re_n);
      if (op_start) begin
        q_kind.push_back(op_kind); q_row.push_back(op_row); q_col.push_back(op_col);
      end
      if (dat_valid) begin
        q_dbyte.push_back(dat_byte); q_dcol.push_back(dat_col);
      end
      if (op_abort) aborts++;
    end
  end

  // kind: 0 command, 1 address, 2 data; bz: -1 keep, 0 idle, 1 busy
  task automatic wr(input int kind, input logic [7:0] v, input int bz);
    @(negedge clk); cle = (kind == 0); ale = (kind == 1); io_in = v; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    if (bz == 0) exp_busy = 0;
    else if (bz == 1) exp_busy = 1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic addr4(input logic [7:0] c, input logic [23:0] r, input int bz);
    wr(1, c, -1); wr(1, r[7:0], -1); wr(1, r[15:8], -1); wr(1, r[23:16], bz);
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); check(io_out == exp, tag, io_out, exp);
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_op(input bit f);
    @(negedge clk); arr_done = 1'b1; arr_fail = f; exp_busy = 0;
    @(negedge clk); arr_done = 1'b0; arr_fail = 1'b0;
  endtask

  task automatic expect_op(input int kind, input int row, input int col, input string tag);
    if (q_kind.size() == 0) check(0, {tag, " no launch"}, 0, kind);
    else begin
      int k = q_kind.pop_front(), r = q_row.pop_front(), c = q_col.pop_front();
      check(k == kind, {tag, " kind"}, k, kind);
      check(r == row, {tag, " row"}, r, row);
      check(c == col, {tag, " col"}, c, col);
    end
  endtask

  task automatic expect_none(input string tag);
    check(q_kind.size() == 0, tag, q_kind.size(), 0);
    q_kind.delete(); q_row.delete(); q_col.delete();
  endtask

  task automatic expect_dat(input int b, input int col, input string tag);
    if (q_dbyte.size() == 0) check(0, {tag, " no data"}, 0, b);
    else begin
      int x = q_dbyte.pop_front(), c = q_dcol.pop_front();
      check(x == b, {tag, " byte"}, x, b);
      check(c == col, {tag, " col"}, c, col);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1; started = 1;
    @(negedge clk);
    check(busy == 0 && io_oe == 0 && op_start == 0, "R7 reset state", busy, 0);

    // R7 idle status after reset
    wr(0, 8'h70, -1); rd(8'hC0, "R7 status after reset");

    // R8 identification bytes with wrap
    wr(0, 8'h90, -1); wr(1, 8'h00, -1);
    rd(8'hEC, "R8 id0"); rd(8'h79, "R8 id1"); rd(8'hA5, "R8 id2");
    rd(8'hC0, "R8 id3"); rd(8'hEC, "R8 id wrap");
    expect_none("R8 id starts nothing");

    // R3 R13 first-half read
    wr(0, 8'h00, -1); addr4(8'h12, 24'h075634, 1);
    expect_op(1, 24'h075634, 10'h012, "R3 read");
    finish_op(0);
    rd(8'h12 ^ 8'h5A, "R13 array byte 0");
    rd(8'h13 ^ 8'h5A, "R13 array byte 1");
    check(rd_col == 10'h014, "R13 column advance", rd_col, 10'h014);
    wr(0, 8'h70, -1); rd(8'hC0, "R7 status idle");

    // R3 repeat read without command; R10 busy behaviour
    addr4(8'h20, 24'h000001, 1);
    expect_op(1, 24'h000001, 10'h020, "R3 bare address read");
    wr(0, 8'h70, -1); rd(8'h80, "R7 status busy");
    wr(0, 8'h60, -1); wr(1, 8'h05, -1);
    finish_op(0);
    wr(0, 8'hD0, -1);
    expect_none("R10 command ignored while busy");

    // R2 pointer regions
    wr(0, 8'h01, -1); addr4(8'h05, 24'h0, 1);
    expect_op(1, 0, 10'h105, "R2 second half"); finish_op(0);
    wr(0, 8'h50, -1); addr4(8'hAB, 24'h2, 1);
    expect_op(1, 2, 10'h20B, "R2 spare area"); finish_op(0);
    addr4(8'h37, 24'h3, 1);
    expect_op(1, 3, 10'h207, "R2 sticky spare"); finish_op(0);

    // R4 R1 R12 erase with stray data and extra address
    wr(0, 8'h60, -1); wr(2, 8'h77, -1);
    wr(1, 8'h11, -1); wr(1, 8'h22, -1); wr(1, 8'h33, -1); wr(1, 8'h44, -1);
    check(q_dbyte.size() == 0, "R1 data byte outside program", q_dbyte.size(), 0);
    wr(0, 8'hD0, 1);
    expect_op(3, 24'h332211, 0, "R4 R12 erase");
    finish_op(1);
    wr(0, 8'h70, -1); rd(8'hC1, "R7 fail bit after erase");
    wr(0, 8'hD0, -1); expect_none("R4 lone confirm");

    // R5 program in sticky spare region, R12 address during data phase
    wr(0, 8'h80, -1); addr4(8'h04, 24'h000001, -1);
    wr(2, 8'hAA, -1); wr(2, 8'hBB, -1); wr(1, 8'h99, -1); wr(2, 8'hCC, -1);
    expect_dat(8'hAA, 10'h204, "R5 data 0");
    expect_dat(8'hBB, 10'h205, "R5 data 1");
    expect_dat(8'hCC, 10'h206, "R5 R12 data 2");
    expect_none("R5 no launch before confirm");
    wr(0, 8'h10, 1);
    expect_op(2, 1, 10'h204, "R5 program");
    finish_op(0);
    wr(0, 8'h70, -1); rd(8'hC0, "R7 pass after program");

    // R6 copy-back
    wr(0, 8'hFF, 0);
    wr(0, 8'h8A, -1); addr4(8'h10, 24'h000002, -1); wr(0, 8'h10, -1);
    expect_none("R6 copy without source");
    wr(0, 8'h00, -1); addr4(8'h00, 24'h000005, 1);
    expect_op(1, 5, 0, "R6 source read"); finish_op(0);
    wr(0, 8'h8A, -1); addr4(8'h10, 24'h000002, -1); wr(0, 8'h10, 1);
    expect_op(4, 2, 10'h010, "R6 copy-back"); finish_op(0);

    // R9 reset command aborts busy
    wr(0, 8'h00, -1); addr4(8'h01, 24'h0, 1);
    expect_op(1, 0, 10'h001, "R9 read before abort");
    wr(0, 8'hFF, 0);
    check(aborts == 1, "R9 abort pulse", aborts, 1);
    wr(0, 8'h70, -1); rd(8'hC0, "R9 status after reset");
    @(negedge clk); wp_n = 1'b0;
    wr(0, 8'hFF, 0); wr(0, 8'h70, -1); rd(8'h40, "R9 status protected");
    check(aborts == 1, "R9 no abort when idle", aborts, 1);
    @(negedge clk); wp_n = 1'b1;

    // R11 unknown command drops the sequence
    wr(0, 8'h60, -1); wr(1, 8'h01, -1); wr(0, 8'h33, -1);
    wr(1, 8'h02, -1); wr(1, 8'h03, -1); wr(0, 8'hD0, -1);
    expect_none("R11 unknown command");
    check(q_dbyte.size() == 0, "R1 no stray data", q_dbyte.size(), 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule